// File: doc/BRIEF.md
# Reply Coalescer

This block sits between a memory controller's read-reply queue and the network interface that carries replies back to the cores. Replies enter in arrival order, each with a data word, a destination core, an approximable flag and a format flag (unsigned integer or floating point). The oldest reply is always the next to leave. If it is not approximable, it leaves at once as a packet for a single destination.

If the oldest reply is approximable, the block looks at a bounded window of the replies queued behind it, one per cycle. A candidate whose value is close enough to the head value, under a relative-error test, is folded into the head: its destination bit is set in the head's destination mask, and the candidate is removed from the queue. Removing it frees its slot at once. When the window is done, the head leaves as a single multicast packet carrying one data word and a destination bitmask. This cuts the reply traffic the network has to carry.

The window length and the error threshold are held in registers that software loads through a write strobe. The threshold is a fixed-point fraction, so the test needs no divider.

Top module: `reply_coalescer`

## Requirements
- R1: A head reply with in_approx = 0 is loaded into the output register on the first cycle the output is free, with no scan. out_mask has only the bit of its own destination set, and out_data equals its data.
- R2: For an approximable head with a window length D > 0, the block examines, in queue order, the first D replies queued behind the head. This takes exactly D cycles. out_valid rises D cycles after the head is taken. Replies further back are not examined.
- R3: A candidate is merged only if its own in_approx was 1 and |h − c| · 2^FRAC_W < T · h, where h is the head value, c the candidate value and T the threshold with FRAC_W fraction bits. The comparison is strict, so equality does not merge. For integer format, the value is the whole unsigned data word.
- R4: When the head value is zero, only a candidate whose value is also zero is merged.
- R5: A merged candidate's destination bit is set in the head's out_mask, together with the head's own bit. The candidate never leaves as a packet of its own. Replies that are not merged leave later in their original relative order.
- R6: With in_fp = 1, the word is read as sign (bit 31), exponent (bits 30:23) and mantissa (bits 22:0). A candidate merges only if it is also floating point and its sign and exponent equal the head's. The R3 test is then applied to the mantissa fields read as unsigned integers. Integer and floating-point replies never merge with each other.
- R7: When cfg_we is high at a clock edge, the window length and threshold are loaded from cfg_depth and cfg_thresh. A window length of 0 disables merging, so every reply is forwarded as in R1.
- R8: While out_valid = 1 and out_ready = 0, out_valid stays high and out_data and out_mask hold their values.
- R9: in_ready is 0 while DEPTH replies are queued and while a scan is in progress. Otherwise it is 1.
- R10: After reset, out_valid = 0 and in_ready = 1. The window length is DEF_DEPTH (4) and the threshold is DEF_THR (16, which is 1/16 with 8 fraction bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A reply is offered |
| in_ready | output | 1 | Reply accepted at this edge when in_valid is also high |
| in_data | input | DATA_W | Reply data word |
| in_dest | input | $clog2(NCORE) | Destination core index |
| in_approx | input | 1 | Reply may be approximated |
| in_fp | input | 1 | Data word is floating point |
| cfg_we | input | 1 | Load window length and threshold |
| cfg_depth | input | $clog2(DEPTH) | Window length (number of replies examined) |
| cfg_thresh | input | FRAC_W+1 | Relative error threshold, fixed point |
| out_valid | output | 1 | Packet available |
| out_ready | input | 1 | Network interface takes the packet |
| out_data | output | DATA_W | Packet data word |
| out_mask | output | NCORE | Destination bitmask |

## Verification
The assertions check on every cycle that the output packet holds under backpressure, that a forwarded head has exactly one destination bit, that a scan lasts as long as its window while the head stays put, and that the queue never overfills. Only the bench scenarios can show what gets merged. These cover the strict threshold boundary, a zero head, floating-point sign, exponent and format mismatches, a match just outside the window, non-approximable candidates, and a fully merged queue. The scoreboard also confirms that unmerged replies come out in order with no packet lost or duplicated.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/coal_queue.sv
// Ordered reply store. Any set of slots can be dropped in one cycle; the
// survivors close up toward slot 0 and a new entry lands behind them.
module coal_queue #(
  parameter int DEPTH = 8,
  parameter int EW    = 38,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [EW-1:0]    push_entry,
  input  logic [DEPTH-1:0] keep,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [EW-1:0]    head,
  output logic [EW-1:0]    cand,
  output logic             cand_present,
  output logic [CNT_W-1:0] count
);

  logic [EW-1:0]    slot_q [DEPTH];
  logic [EW-1:0]    slot_n [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    logic [CNT_W-1:0] wr;
    wr = '0;
    for (int i = 0; i < DEPTH; i++) slot_n[i] = slot_q[i];
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt_q && keep[i]) begin
        slot_n[wr[IDX_W-1:0]] = slot_q[i];
        wr = wr + 1'b1;
      end
    end
    if (push && wr < CNT_W'(DEPTH)) begin
      slot_n[wr[IDX_W-1:0]] = push_entry;
      wr = wr + 1'b1;
    end
    cnt_n = wr;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_n[i];
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign head         = slot_q[0];
  assign cand         = slot_q[rd_idx];
  assign cand_present = CNT_W'(rd_idx) < cnt_q;
  assign count        = cnt_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < CNT_W'(DEPTH)));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/coal_match.sv
// Relative closeness test between the head and one candidate, done with a
// multiply instead of a divide.
module coal_match #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 8,
  parameter int TH_W   = 9
) (
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_fp,
  input  logic [DATA_W-1:0] cand_data,
  input  logic              cand_fp,
  input  logic              cand_apx,
  input  logic [TH_W-1:0]   thresh,
  output logic              hit
);

  localparam int MAN_W = DATA_W - 1 - EXP_W;
  localparam int PW    = DATA_W + FRAC_W + TH_W;

  logic [DATA_W-1:0] hv, cv, diff;
  logic [PW-1:0]     lhs, rhs;
  logic              field_ok, close;

  always_comb begin
    if (head_fp) begin
      hv       = DATA_W'(head_data[MAN_W-1:0]);
      cv       = DATA_W'(cand_data[MAN_W-1:0]);
      field_ok = head_data[DATA_W-1:MAN_W] == cand_data[DATA_W-1:MAN_W];
    end else begin
      hv       = head_data;
      cv       = cand_data;
      field_ok = 1'b1;
    end
    diff = (hv >= cv) ? (hv - cv) : (cv - hv);
    lhs  = PW'(diff) << FRAC_W;
    rhs  = PW'(hv) * PW'(thresh);
    if (hv == '0) close = (cv == '0);
    else          close = lhs < rhs;
    hit = cand_apx && (head_fp == cand_fp) && field_ok && close;
  end

endmodule

// File: rtl/coal_scan.sv
// Head handling: forward directly or walk the window one candidate per
// cycle, then load the registered output packet.
module coal_scan
  import coal_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEST_W = 4,
  parameter int NCORE  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  q_count,
  input  logic [DATA_W-1:0] head_data,
  input  logic [DEST_W-1:0] head_dest,
  input  logic              head_apx,
  input  logic              cand_present,
  input  logic              cand_hit,
  input  logic [DEST_W-1:0] cand_dest,
  input  logic [IDX_W-1:0]  win_len,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  keep,
  output logic              busy,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [NCORE-1:0]  out_mask
);

  scan_state_t       st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  left_q;
  logic [NCORE-1:0]  acc_q, acc_n;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;
  logic [NCORE-1:0]  om_q;
  logic              out_free, take_head, direct, merge, last;
  logic [NCORE-1:0]  head_bit;

  always_comb begin
    head_bit  = NCORE'(1) << head_dest;
    out_free  = !ov_q || out_ready;
    take_head = (st_q == ST_IDLE) && (q_count != '0) && out_free;
    direct    = take_head && (!head_apx || win_len == '0);
    merge     = (st_q == ST_SCAN) && cand_present && cand_hit;
    last      = (st_q == ST_SCAN) && (left_q == IDX_W'(1));
    acc_n     = acc_q;
    if (merge) acc_n = acc_q | (NCORE'(1) << cand_dest);
    keep = '1;
    if (merge) keep[idx_q] = 1'b0;
    if (direct || last) keep[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      left_q <= '0;
      acc_q  <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
      om_q   <= '0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (direct) begin
            ov_q <= 1'b1;
            od_q <= head_data;
            om_q <= head_bit;
          end else if (take_head) begin
            st_q   <= ST_SCAN;
            idx_q  <= IDX_W'(1);
            left_q <= win_len;
            acc_q  <= head_bit;
          end
        end
        default: begin
          acc_q  <= acc_n;
          left_q <= left_q - 1'b1;
          if (!merge && idx_q != IDX_W'(DEPTH - 1)) idx_q <= idx_q + 1'b1;
          if (last) begin
            st_q <= ST_IDLE;
            ov_q <= 1'b1;
            od_q <= head_data;
            om_q <= acc_n;
          end
        end
      endcase
    end
  end

  assign rd_idx    = idx_q;
  assign busy      = (st_q == ST_SCAN);
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_mask  = om_q;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !out_ready) |=> (ov_q && $stable(od_q) && $stable(om_q)));

  // R1
  single_dest_chk: assert property (@(posedge clk) disable iff (rst)
    direct |=> (ov_q && $countones(om_q) == 1));

  // R2
  scan_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SCAN && left_q > IDX_W'(1)) |=> (st_q == ST_SCAN && !ov_q));

  // R2
  head_still_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SCAN) |-> ($stable(head_data) && $stable(head_dest)));

  // R5
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> (om_q != '0));

endmodule

// File: rtl/reply_coalescer.sv
module reply_coalescer #(
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 32,
  parameter int NCORE     = 16,
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 8,
  parameter int DEF_DEPTH = 4,
  parameter int DEF_THR   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [$clog2(NCORE)-1:0] in_dest,
  input  logic                     in_approx,
  input  logic                     in_fp,
  input  logic                     cfg_we,
  input  logic [$clog2(DEPTH)-1:0] cfg_depth,
  input  logic [FRAC_W:0]          cfg_thresh,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data,
  output logic [NCORE-1:0]         out_mask
);

  localparam int DEST_W = $clog2(NCORE);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int TH_W   = FRAC_W + 1;
  localparam int EW     = DATA_W + DEST_W + 2;
  localparam int FP_B   = DATA_W + DEST_W;
  localparam int APX_B  = DATA_W + DEST_W + 1;

  logic [IDX_W-1:0] win_q;
  logic [TH_W-1:0]  thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= IDX_W'(DEF_DEPTH);
      thr_q <= TH_W'(DEF_THR);
    end else if (cfg_we) begin
      win_q <= cfg_depth;
      thr_q <= cfg_thresh;
    end
  end

  logic             push, busy, cand_present, hit;
  logic [EW-1:0]    head, cand;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] keep;
  logic [IDX_W-1:0] rd_idx;

  assign in_ready = !busy && (count != CNT_W'(DEPTH));
  assign push     = in_valid && in_ready;

  coal_queue #(
    .DEPTH(DEPTH), .EW(EW), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_queue (
    .clk         (clk),
    .rst         (rst),
    .push        (push),
    .push_entry  ({in_approx, in_fp, in_dest, in_data}),
    .keep        (keep),
    .rd_idx      (rd_idx),
    .head        (head),
    .cand        (cand),
    .cand_present(cand_present),
    .count       (count)
  );

  coal_match #(
    .DATA_W(DATA_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .TH_W(TH_W)
  ) u_match (
    .head_data(head[DATA_W-1:0]),
    .head_fp  (head[FP_B]),
    .cand_data(cand[DATA_W-1:0]),
    .cand_fp  (cand[FP_B]),
    .cand_apx (cand[APX_B]),
    .thresh   (thr_q),
    .hit      (hit)
  );

  coal_scan #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .DATA_W(DATA_W), .DEST_W(DEST_W), .NCORE(NCORE)
  ) u_scan (
    .clk         (clk),
    .rst         (rst),
    .q_count     (count),
    .head_data   (head[DATA_W-1:0]),
    .head_dest   (head[DATA_W+:DEST_W]),
    .head_apx    (head[APX_B]),
    .cand_present(cand_present),
    .cand_hit    (hit),
    .cand_dest   (cand[DATA_W+:DEST_W]),
    .win_len     (win_q),
    .out_ready   (out_ready),
    .rd_idx      (rd_idx),
    .keep        (keep),
    .busy        (busy),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_mask    (out_mask)
  );

  // R9
  no_push_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !push);

endmodule

// File: tb/reply_coalescer_tb.sv
module reply_coalescer_tb;

  typedef struct {
    bit          apx;
    bit          fp;
    logic [31:0] data;
    int          dest;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [3:0]  in_dest = '0;
  logic        in_approx = 1'b0;
  logic        in_fp = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_depth = '0;
  logic [8:0]  cfg_thresh = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [15:0] out_mask;

  int checks = 0;
  int fails  = 0;
  int cur_depth = 4;
  int cur_thr   = 16;

  logic [31:0] exp_data[$];
  logic [15:0] exp_mask[$];
  string       exp_tag[$];

  always #2 clk = ~clk;

  reply_coalescer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_dest(in_dest), .in_approx(in_approx), .in_fp(in_fp),
    .cfg_we(cfg_we), .cfg_depth(cfg_depth), .cfg_thresh(cfg_thresh),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_mask(out_mask)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_data.size() == 0) begin
        check(1'b0, "R5", "unexpected packet data", out_data, 0);
      end else begin
        logic [31:0] d;
        logic [15:0] m;
        string t;
        d = exp_data.pop_front();
        m = exp_mask.pop_front();
        t = exp_tag.pop_front();
        check(out_data == d, t, "packet data", out_data, d);
        check(out_mask == m, t, "packet mask", out_mask, m);
      end
    end
  end

  function automatic bit near(ent_t h, ent_t c, int thr);
    longint hv, cv, df;
    if (!c.apx || h.fp != c.fp) return 1'b0;
    if (h.fp) begin
      if (h.data[31:23] != c.data[31:23]) return 1'b0;
      hv = longint'(h.data[22:0]);
      cv = longint'(c.data[22:0]);
    end else begin
      hv = longint'(h.data);
      cv = longint'(c.data);
    end
    if (hv == 0) return cv == 0;
    df = (hv > cv) ? hv - cv : cv - hv;
    return (df * 256) < (longint'(thr) * hv);
  endfunction

  task automatic expect_pkt(logic [31:0] d, logic [15:0] m, string t);
    exp_data.push_back(d);
    exp_mask.push_back(m);
    exp_tag.push_back(t);
  endtask

  task automatic model(ent_t b[$], string tag);
    ent_t q[$];
    q = b;
    while (q.size() > 0) begin
      ent_t h;
      logic [15:0] m;
      h = q.pop_front();
      m = 16'(1) << h.dest;
      if (h.apx && cur_depth > 0) begin
        int j;
        j = 0;
        for (int e = 0; e < cur_depth && j < q.size(); e++) begin
          if (near(h, q[j], cur_thr)) begin
            m[q[j].dest] = 1'b1;
            q.delete(j);
          end else begin
            j++;
          end
        end
      end
      expect_pkt(h.data, m, tag);
    end
  endtask

  task automatic push_one(ent_t e);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = e.data; in_dest = 4'(e.dest);
    in_approx = e.apx; in_fp = e.fp;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(int d, int t);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_depth = 3'(d); cfg_thresh = 9'(t);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    cur_depth = d; cur_thr = t;
  endtask

  function automatic ent_t mk(bit a, bit f, logic [31:0] d, int dst);
    ent_t e;
    e.apx = a; e.fp = f; e.data = d; e.dest = dst;
    return e;
  endfunction

  int batch_no = 0;

  task automatic run_batch(ent_t b[$], string tag);
    ent_t blk;
    int lat, exp_lat;
    batch_no++;
    out_ready = 1'b0;
    blk = mk(1'b0, 1'b0, 32'hB10C_0000 + 32'(batch_no), 15);
    push_one(blk);
    expect_pkt(blk.data, 16'h8000, tag);
    repeat (3) @(posedge clk);
    foreach (b[i]) push_one(b[i]);
    @(negedge clk);
    // R8: packet held while the network interface stalls
    check(out_valid == 1'b1 && out_data == blk.data, "R8", "held packet",
          out_data, blk.data);
    if (b.size() == 8)
      check(in_ready == 1'b0, "R9", "in_ready with full queue", in_ready, 0);
    model(b, tag);
    exp_lat = (b[0].apx && cur_depth > 0) ? cur_depth : 0;
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    while (!out_valid && lat < 100) begin
      lat++;
      @(negedge clk);
    end
    check(lat == exp_lat, (exp_lat == 0) ? "R1" : "R2", "cycles to packet", lat, exp_lat);
    for (int k = 0; k < 200 && exp_data.size() > 0; k++) @(posedge clk);
    repeat (10) @(posedge clk);
    check(exp_data.size() == 0, "R5", "packets missing", exp_data.size(), 0);
    exp_data.delete(); exp_mask.delete(); exp_tag.delete();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    ent_t b[$];
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);

    // R1: non-approximable head passes alone although a twin follows
    b = {};
    b.push_back(mk(1'b0, 1'b0, 32'd1000, 3));
    b.push_back(mk(1'b1, 1'b0, 32'd1000, 4));
    run_batch(b, "R1");

    // R10 defaults (window 4, threshold 16), R2/R3 window and threshold
    b = {};
    b.push_back(mk(1'b1, 1'b0, 32'd1000, 1));
    b.push_back(mk(1'b1, 1'b0, 32'd1010, 2));
    b.push_back(mk(1'b1, 1'b0, 32'd1100, 3));
    b.push_back(mk(1'b1, 1'b0, 32'd990, 4));
    b.push_back(mk(1'b0, 1'b0, 32'd1000, 5));
    b.push_back(mk(1'b1, 1'b0, 32'd1001, 6));
    run_batch(b, "R2");

    // R3: strict boundary (equality does not merge)
    set_cfg(4, 16);
    b = {};
    b.push_back(mk(1'b1, 1'b0, 32'd256, 0));
    b.push_back(mk(1'b1, 1'b0, 32'd272, 1));
    b.push_back(mk(1'b1, 1'b0, 32'd271, 2));
    b.push_back(mk(1'b1, 1'b0, 32'd241, 3));
    run_batch(b, "R3");

    // R4: zero head
    b = {};
    b.push_back(mk(1'b1, 1'b0, 32'd0, 0));
    b.push_back(mk(1'b1, 1'b0, 32'd1, 2));
    b.push_back(mk(1'b1, 1'b0, 32'd0, 1));
    run_batch(b, "R4");

    // R6: floating point fields
    b = {};
    b.push_back(mk(1'b1, 1'b1, 32'h3FC0_0000, 0));
    b.push_back(mk(1'b1, 1'b1, 32'h3FC0_0100, 1));
    b.push_back(mk(1'b1, 1'b1, 32'h4040_0000, 2));
    b.push_back(mk(1'b1, 1'b1, 32'hBFC0_0000, 3));
    b.push_back(mk(1'b1, 1'b0, 32'h3FC0_0000, 4));
    run_batch(b, "R6");

    // R7: window length 0 disables merging
    set_cfg(0, 16);
    b = {};
    b.push_back(mk(1'b1, 1'b0, 32'd500, 7));
    b.push_back(mk(1'b1, 1'b0, 32'd500, 8));
    run_batch(b, "R7");

    // R9/R5: full queue, everything merges into one packet
    set_cfg(7, 32);
    b = {};
    for (int i = 0; i < 8; i++) b.push_back(mk(1'b1, 1'b0, 32'd77, i));
    run_batch(b, "R9");

    // R3: wider threshold, mixed order
    set_cfg(3, 64);
    b = {};
    b.push_back(mk(1'b1, 1'b0, 32'd4000, 9));
    b.push_back(mk(1'b1, 1'b0, 32'd5000, 10));
    b.push_back(mk(1'b1, 1'b0, 32'd4900, 11));
    b.push_back(mk(1'b1, 1'b0, 32'd4001, 12));
    b.push_back(mk(1'b1, 1'b0, 32'd5001, 13));
    run_batch(b, "R3");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule